// File: doc/BRIEF.md
# Fractional Divide-Ratio Sigma-Delta Modulator

This block sits beside the feedback divider of a frequency synthesizer. It runs at the comparison rate. At every comparison edge it produces a small signed correction that is added to a programmed integer divide ratio, so that the divider alternates between neighbouring ratios. The long-run mean of the correction equals a signed fraction F/62976. The fraction is a 17-bit two's-complement word F, limited to the span -31488..+31488, which is -0.5 to +0.5 of one divide step.

Three cascaded first-order accumulators produce the correction, and a noise-shaping combiner merges their carries. Each accumulator wraps at the non-binary modulus 62976. A two-state controller selects between two modes:

- **INT**: pure integer division. The correction is zero and the output is the base ratio.
- **FRAC**: fractional division.

The transitions are:

- **ENGAGE**: from INT to FRAC when `frac_en` is sampled high.
- **RELEASE**: from FRAC to INT when `frac_en` is sampled low.
- A synchronous reset forces INT from either state.

Leaving FRAC clears all modulator history. The synchronous reset also serves as the counter-reset control and clears the whole modulator.

Top module: `fsd_modulator`

## Requirements
- R1: While `srst` is high at a clock edge, `offset` and `total_n` become 0, the state becomes INT and all accumulators and carry history are cleared. The output sequence after the reset is therefore identical to the sequence from power-up.
- R2: With `frac_en` high, each edge updates three accumulators, each modulo 62976. Stage 1 adds the input value x. Stage 2 adds stage 1's new remainder. Stage 3 adds stage 2's new remainder. A stage carries 1 when its sum reaches 62976, and it then keeps the sum minus 62976. The correction is c1 + (c2 - c2') + (c3 - 2·c3' + c3''), where ' marks the value from one edge earlier and '' from two edges earlier.
- R3: `frac_word` is two's complement; for example, -2 is encoded as 17'h1FFFE. For a negative F, x = F + 62976 and the correction is reduced by one. For F ≥ 0, x = F.
- R4: `offset` is a 4-bit two's-complement value. It lies in -3..+4 when F ≥ 0 and in -4..+3 when F < 0.
- R5: With `frac_en` low at an edge (RELEASE or staying in INT), `offset` becomes 0 and `total_n` becomes `base_n`. All history is cleared, so a later ENGAGE restarts the sequence exactly as after reset.
- R6: `total_n` equals `base_n` plus `offset`, both taken from the same edge. `base_n` and `frac_word` are sampled at each edge, so a change takes effect in the very next output without disturbing the accumulators.
- R7: Starting from a cleared state, consider 62976 consecutive fractional cycles with a constant F. The sum of the offsets equals F plus an end term in -1..+2. That end term is the pending carry of stages 2 and 3, and it is exactly the value given by R2.
- R8: With F = 0 in FRAC mode, `offset` stays 0 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison-rate clock |
| srst | input | 1 | Synchronous reset / counter reset, active high |
| frac_en | input | 1 | Fractional mode select |
| frac_word | input | 17 | Signed fraction numerator F (two's complement) |
| base_n | input | 10 | Integer divide ratio |
| offset | output | 4 | Signed correction applied this cycle |
| total_n | output | 11 | Registered instantaneous divide ratio |

## Verification
On every cycle, the in-module properties check the following:

- each accumulator remainder stays below the modulus;
- the correction stays inside its sign-dependent range;
- INT mode always shows a zero correction;
- the total output equals the sampled base plus the correction.

Only the bench scenarios can show the following:

- the exact carry sequence of the cascade;
- the restart after RELEASE and ENGAGE;
- the mid-run fraction changes;
- the full-period sums for positive, negative and zero fractions.

The bench compares these against its own cycle model and against the period-sum bound.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    typedef enum logic {
        ST_INT  = 1'b0,
        ST_FRAC = 1'b1
    } fsd_mode_e;

    localparam int unsigned FSD_MOD_DEFAULT = 62976;
endpackage

// File: rtl/fsd_mod_stage.sv
module fsd_mod_stage #(
    parameter int unsigned MOD = 62976,
    parameter int          AW  = 16
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          run,
    input  logic [AW-1:0] addend,
    output logic [AW-1:0] rem_nxt,
    output logic          carry
);
    localparam logic [AW:0] MODV = (AW+1)'(MOD);

    logic [AW-1:0] acc_q;
    logic [AW:0]   raw;

    always_comb begin
        raw     = {1'b0, acc_q} + {1'b0, addend};
        carry   = (raw >= MODV);
        rem_nxt = carry ? AW'(raw - MODV) : raw[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (srst || !run) acc_q <= '0;
        else              acc_q <= rem_nxt;
    end

    // R2: remainder never reaches the modulus
    p_acc_range_r2: assert property (@(posedge clk) disable iff (srst)
        1'b1 |=> ({1'b0, acc_q} < MODV));
endmodule

// File: rtl/fsd_noise_comb.sv
module fsd_noise_comb #(
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          run,
    input  logic          neg,
    input  logic [2:0]    carry,
    output logic [OW-1:0] off_nxt,
    output logic [OW-1:0] off_q
);
    logic c2_d, c3_d, c3_dd;

    function automatic logic [OW-1:0] ext(input logic b);
        return {{(OW-1){1'b0}}, b};
    endfunction

    always_comb begin
        if (run)
            off_nxt = ext(carry[0])
                    + ext(carry[1]) - ext(c2_d)
                    + ext(carry[2]) - (ext(c3_d) << 1) + ext(c3_dd)
                    - ext(neg);
        else
            off_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (srst || !run) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
            off_q <= '0;
        end else begin
            c2_d  <= carry[1];
            c3_d  <= carry[2];
            c3_dd <= c3_d;
            off_q <= off_nxt;
        end
    end

    // R4: sign-dependent correction range
    p_offset_pos_r4: assert property (@(posedge clk) disable iff (srst)
        (run && !neg) |=> ($signed(off_q) >= -3 && $signed(off_q) <= 4));
    p_offset_neg_r4: assert property (@(posedge clk) disable iff (srst)
        (run && neg) |=> ($signed(off_q) >= -4 && $signed(off_q) <= 3));
endmodule

// File: rtl/fsd_modulator.sv
module fsd_modulator
    import fsd_pkg::*;
#(
    parameter int unsigned MOD = FSD_MOD_DEFAULT,
    parameter int          FW  = 17,
    parameter int          NW  = 10
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          frac_en,
    input  logic [FW-1:0] frac_word,
    input  logic [NW-1:0] base_n,
    output logic [3:0]    offset,
    output logic [NW:0]   total_n
);
    localparam int AW     = $clog2(MOD);
    localparam int OW     = 4;
    localparam int STAGES = 3;

    fsd_mode_e     state_q, state_nxt;
    logic          run;
    logic          neg;
    logic [AW-1:0] x_in;
    logic [AW-1:0] addend [STAGES];
    logic [AW-1:0] rem    [STAGES];
    logic [2:0]    carry;
    logic [OW-1:0] off_nxt, off_q;
    logic [NW:0]   total_nxt, total_q;

    // state register
    always_ff @(posedge clk) begin
        if (srst) state_q <= ST_INT;
        else      state_q <= state_nxt;
    end

    // transitions: ENGAGE / RELEASE
    always_comb begin
        unique case (state_q)
            ST_INT:  state_nxt = frac_en ? ST_FRAC : ST_INT;
            ST_FRAC: state_nxt = frac_en ? ST_FRAC : ST_INT;
            default: state_nxt = ST_INT;
        endcase
    end

    // signed fraction folded into the unsigned accumulator range
    always_comb begin
        neg  = frac_word[FW-1];
        x_in = neg ? AW'(frac_word + FW'(MOD)) : AW'(frac_word);
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign addend[i] = x_in;
        end else begin : g_chain
            assign addend[i] = rem[i-1];
        end
        fsd_mod_stage #(.MOD(MOD), .AW(AW)) u_stage (
            .clk    (clk),
            .srst   (srst),
            .run    (run),
            .addend (addend[i]),
            .rem_nxt(rem[i]),
            .carry  (carry[i])
        );
    end

    fsd_noise_comb #(.OW(OW)) u_comb (
        .clk    (clk),
        .srst   (srst),
        .run    (run),
        .neg    (neg),
        .carry  (carry),
        .off_nxt(off_nxt),
        .off_q  (off_q)
    );

    // outputs
    always_comb begin
        unique case (state_nxt)
            ST_FRAC: begin
                run       = 1'b1;
                total_nxt = (NW+1)'({1'b0, base_n}
                          + {{(NW+1-OW){off_nxt[OW-1]}}, off_nxt});
            end
            default: begin
                run       = 1'b0;
                total_nxt = {1'b0, base_n};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) total_q <= '0;
        else      total_q <= total_nxt;
    end

    assign offset  = off_q;
    assign total_n = total_q;

    // R5: integer mode never shows a correction
    p_int_zero_r5: assert property (@(posedge clk) disable iff (srst)
        (state_q == ST_INT) |-> (offset == '0));

    // R6: total is sampled base plus the correction
    p_total_sum_r6: assert property (@(posedge clk) disable iff (srst)
        1'b1 |=> ($signed({1'b0, total_n}) ==
                  $signed({2'b00, $past(base_n)})
                  + $signed({{(NW+2-OW){offset[OW-1]}}, offset})));

    // R2: last stage remainder stays within the modulus
    p_tail_range_r2: assert property (@(posedge clk) disable iff (srst)
        run |-> ({1'b0, rem[STAGES-1]} < (AW+1)'(MOD)));
endmodule

// File: tb/fsd_modulator_tb.sv
`timescale 1ns/1ps
module fsd_modulator_tb;
    localparam int M = 62976;

    logic        clk = 1'b0;
    logic        srst;
    logic        frac_en;
    logic [16:0] frac_word;
    logic [9:0]  base_n;
    logic [3:0]  offset;
    logic [10:0] total_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    int a1, a2, a3, c2d, c3d, c3dd, e_off, e_tot;

    always #5 clk = ~clk;

    fsd_modulator u_dut (
        .clk(clk), .srst(srst), .frac_en(frac_en), .frac_word(frac_word),
        .base_n(base_n), .offset(offset), .total_n(total_n)
    );

    function automatic int act_off();
        return int'($signed(offset));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0;
    endtask

    // one comparison edge of the modulator per R1..R6
    task automatic model_step(input bit r, input bit en, input int f, input int b);
        int x, s, c1, c2, c3;
        if (r) begin
            model_clear(); e_off = 0; e_tot = 0;
        end else if (!en) begin
            model_clear(); e_off = 0; e_tot = b;
        end else begin
            x = (f < 0) ? f + M : f;
            s = a1 + x; c1 = (s >= M); a1 = c1 ? s - M : s;
            s = a2 + a1; c2 = (s >= M); a2 = c2 ? s - M : s;
            s = a3 + a2; c3 = (s >= M); a3 = c3 ? s - M : s;
            e_off = c1 + c2 - c2d + c3 - 2*c3d + c3dd - ((f < 0) ? 1 : 0);
            c2d = c2; c3dd = c3d; c3d = c3;
            e_tot = b + e_off;
        end
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit r, input bit en, input int f, input int b, input string tag);
        srst = r; frac_en = en; frac_word = f[16:0]; base_n = b[9:0];
        @(posedge clk);
        model_step(r, en, f, b);
        @(negedge clk);
        check({tag, " offset"}, act_off(), e_off);
        check("R6 total", int'(total_n), e_tot);
    endtask

    task automatic window(input int f, input int b);
        int sum;
        int msum;
        sum = 0; msum = 0;
        cyc(1'b1, 1'b0, 0, b, "R1");
        for (int i = 0; i < M; i++) begin
            cyc(1'b0, 1'b1, f, b, "R2");
            sum  += act_off();
            msum += e_off;
        end
        check("R7 period sum exact", sum, msum);
        n_chk++;
        if (sum - f < -1 || sum - f > 2) begin
            n_bad++;
            $display("FAIL R7 period sum actual=%0d expected=%0d(-1..+2)", sum, f);
        end
    endtask

    initial begin
        int f, b, o;
        void'($urandom(32'd20240611));
        srst = 1'b1; frac_en = 1'b0; frac_word = '0; base_n = 10'd100;
        model_clear();

        // R1: reset state
        cyc(1'b1, 1'b0, 0, 100, "R1");
        cyc(1'b1, 1'b1, 5000, 100, "R1");
        check("R1 total after reset", int'(total_n), 0);

        // R5: integer mode
        cyc(1'b0, 1'b0, 12345, 300, "R5");
        check("R5 base passthrough", int'(total_n), 300);
        cyc(1'b0, 1'b0, -900, 777, "R5");

        // R8: zero fraction
        begin
            int zs;
            zs = 0;
            for (int i = 0; i < 3000; i++) begin
                cyc(1'b0, 1'b1, 0, 500, "R8");
                if (act_off() != 0) zs++;
            end
            check("R8 nonzero count", zs, 0);
        end

        // R3: -2 encoded 17'h1FFFE, and boundary words
        cyc(1'b1, 1'b0, 0, 200, "R1");
        for (int i = 0; i < 200; i++) cyc(1'b0, 1'b1, -2, 200, "R3");
        cyc(1'b1, 1'b0, 0, 200, "R1");
        for (int i = 0; i < 200; i++) cyc(1'b0, 1'b1, 31488, 200, "R3");
        cyc(1'b1, 1'b0, 0, 200, "R1");
        for (int i = 0; i < 200; i++) cyc(1'b0, 1'b1, -31488, 200, "R3");

        // R7: full periods, positive and negative
        window(20000, 800);
        window(-31488, 72);

        // R5/R6/R4: random mix with fraction and base changes mid-run
        for (int seg = 0; seg < 20; seg++) begin
            for (int i = 0; i < 300; i++) begin
                f = int'($urandom_range(62976)) - 31488;
                if (($urandom_range(7)) != 0 && i > 0) f = f / 64;
                b = 72 + int'($urandom_range(936));
                cyc(($urandom_range(150) == 0), ($urandom_range(20) != 0), f, b, "R5");
                o = act_off();
                n_chk++;
                if (o < -4 || o > 4) begin
                    n_bad++;
                    $display("FAIL R4 range actual=%0d expected=-4..4", o);
                end
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule